// File: doc/BRIEF.md
# Power-Good Window Supervisor with Voltage-Code Masking

This block derives a power-good flag from a digital measure of feedback voltage, given as a percentage of the target. The flag follows a window with separate fault and recovery levels on each side, so a marginal feedback value cannot make it chatter. A flag that is good survives inside the wide band. A flag that is bad needs the feedback to come back into the narrower recovery band.

When the output voltage code is changed, the regulator slews to a new target and the feedback briefly leaves the window. A strobe marks each accepted code change. The block then forces continuous-conduction mode and freezes the power-good flag at its present value for a fixed number of clocks. A strobe that lands during an interval that is still running starts the interval again from its full length.

A separate timer raises a ready flag for the serial control port once enable has been high for a set time after start-up. All thresholds and interval lengths are parameters. The interval lengths are counted in system clocks.

Top module: `pg_window_supervisor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `pgood_o`, `force_ccm_o` and `ser_ready_o` are all 0.
- R2: A registered window state goes bad on the clock edge where `fb_pct_i` is below LO_FAULT (default 80). `pgood_o` follows that window state one clock edge later.
- R3: Once the window state is bad, it becomes good only when `fb_pct_i` is strictly above LO_GOOD (default 85) and strictly below HI_GOOD. A value in LO_FAULT..LO_GOOD inclusive leaves the state unchanged.
- R4: The window state goes bad when `fb_pct_i` is strictly above HI_FAULT (default 125). The value HI_FAULT itself does not cause a fault.
- R5: After a high-side fault, the state recovers only when `fb_pct_i` is strictly below HI_GOOD (default 120). A value in HI_GOOD..HI_FAULT inclusive holds the state.
- R6: While `en_i` or `ss_done_i` is 0, the window state and `pgood_o` are driven to 0 at every edge.
- R7: A `vid_chg_i` pulse sampled with `en_i`=1 makes `force_ccm_o` 1 for exactly MASK_CYC cycles, starting on the cycle after the edge where the pulse was sampled.
- R8: On the edge that samples an accepted strobe, and on every edge while `force_ccm_o` is 1, `pgood_o` keeps its value, provided `en_i` and `ss_done_i` are both 1.
- R9: A strobe sampled while the interval is running reloads the interval to MASK_CYC.
- R10: A `vid_chg_i` pulse sampled with `en_i`=0 has no effect. `force_ccm_o` stays 0, and any running interval is cleared.
- R11: `ser_ready_o` becomes 1 after `en_i` has been sampled high on READY_CYC consecutive edges. It returns to 0 on the edge after `en_i` is sampled low.
- R12: The window state keeps following `fb_pct_i` while power good is frozen. On the first edge after the interval ends, `pgood_o` takes the current window state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Regulator enable |
| ss_done_i | input | 1 | Soft start has completed |
| vid_chg_i | input | 1 | One-cycle strobe for an accepted voltage-code change |
| fb_pct_i | input | PCT_W (8) | Feedback relative to target, in 1% units, unsigned |
| pgood_o | output | 1 | Power-good flag |
| force_ccm_o | output | 1 | Forces continuous-conduction mode during a code change |
| ser_ready_o | output | 1 | Enables the serial control port |

## Verification
The bench keeps the default thresholds of 80/85/120/125. This lets directed steps hit each edge value (79, 80, 85, 86, 119, 120, 125, 126) against the documented percentages.

MASK_CYC is reduced to 12 and READY_CYC to 40. With these lengths a masking interval, its retrigger part-way through, its expiry, and the ready delay all fit into a few dozen cycles. Thousands of random cycles can therefore cross many interval ends and enable drops.

// File: rtl/pg_sup_pkg.sv
package pg_sup_pkg;

   // Classification of one feedback sample against the hysteresis window
   typedef enum logic [1:0] {
      WIN_KEEP  = 2'd0,
      WIN_FAULT = 2'd1,
      WIN_GOOD  = 2'd2
   } win_evt_e;

   // Counter width that can hold the value n
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/pg_hyst_window.sv
module pg_hyst_window
   import pg_sup_pkg::*;
#(
   parameter int unsigned PCT_W    = 8,
   parameter int unsigned LO_FAULT = 80,
   parameter int unsigned LO_GOOD  = 85,
   parameter int unsigned HI_GOOD  = 120,
   parameter int unsigned HI_FAULT = 125
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active_i,
   input  logic [PCT_W-1:0] fb_i,
   output logic             in_win_o
);
   localparam logic [PCT_W-1:0] LF = PCT_W'(LO_FAULT);
   localparam logic [PCT_W-1:0] LG = PCT_W'(LO_GOOD);
   localparam logic [PCT_W-1:0] HG = PCT_W'(HI_GOOD);
   localparam logic [PCT_W-1:0] HF = PCT_W'(HI_FAULT);

   if (!(LO_FAULT <= LO_GOOD && LO_GOOD < HI_GOOD && HI_GOOD <= HI_FAULT))
      $error("pg_hyst_window: thresholds out of order");
   if (HI_FAULT >= (1 << PCT_W))
      $error("pg_hyst_window: HI_FAULT does not fit PCT_W");

   win_evt_e evt;
   logic     state_q;

   always_comb begin
      if (fb_i < LF || fb_i > HF)      evt = WIN_FAULT;
      else if (fb_i > LG && fb_i < HG) evt = WIN_GOOD;
      else                             evt = WIN_KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             state_q <= 1'b0;
      else if (!active_i)     state_q <= 1'b0;
      else begin
         unique case (evt)
            WIN_FAULT: state_q <= 1'b0;
            WIN_GOOD:  state_q <= 1'b1;
            default:   state_q <= state_q;
         endcase
      end
   end

   assign in_win_o = state_q;

   a_r2_low_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (fb_i < LF) |=> !in_win_o);
   a_r4_high_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (fb_i > HF) |=> !in_win_o);
   a_r3_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && fb_i >= LF && fb_i <= LG) |=> (in_win_o == $past(in_win_o)));

endmodule

// File: rtl/pg_retrig_timer.sv
module pg_retrig_timer
   import pg_sup_pkg::*;
#(
   parameter int unsigned LEN = 25000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic load_i,
   output logic busy_o
);
   localparam int unsigned CW = cnt_w(LEN);
   localparam logic [CW-1:0] FULL = CW'(LEN);

   if (LEN < 1) $error("pg_retrig_timer: LEN must be at least 1");

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clear_i)        cnt_q <= '0;
      else if (load_i)         cnt_q <= FULL;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

   a_r9_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !clear_i) |=> (cnt_q == FULL));
   a_r10_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !busy_o);
   a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/pg_ready_timer.sv
module pg_ready_timer
   import pg_sup_pkg::*;
#(
   parameter int unsigned LEN = 425000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic ready_o
);
   if (LEN == 0) begin : g_direct
      logic rdy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdy_q <= 1'b0;
         else        rdy_q <= en_i;
      end
      assign ready_o = rdy_q;
   end else begin : g_count
      localparam int unsigned CW = cnt_w(LEN);
      localparam logic [CW-1:0] DONE = CW'(LEN);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             cnt_q <= '0;
         else if (!en_i)         cnt_q <= '0;
         else if (cnt_q != DONE) cnt_q <= cnt_q + 1'b1;
      end
      assign ready_o = (cnt_q == DONE);
   end

   a_r11_drop_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !ready_o);

endmodule

// File: rtl/pg_window_supervisor.sv
module pg_window_supervisor
   import pg_sup_pkg::*;
#(
   parameter int unsigned PCT_W     = 8,
   parameter int unsigned LO_FAULT  = 80,
   parameter int unsigned LO_GOOD   = 85,
   parameter int unsigned HI_GOOD   = 120,
   parameter int unsigned HI_FAULT  = 125,
   parameter int unsigned MASK_CYC  = 25000,
   parameter int unsigned READY_CYC = 425000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             ss_done_i,
   input  logic             vid_chg_i,
   input  logic [PCT_W-1:0] fb_pct_i,
   output logic             pgood_o,
   output logic             force_ccm_o,
   output logic             ser_ready_o
);
   logic active;
   logic strobe_ok;
   logic in_win;
   logic mask_busy;
   logic hold;
   logic pg_q;

   assign active    = en_i & ss_done_i;
   assign strobe_ok = en_i & vid_chg_i;

   pg_hyst_window #(
      .PCT_W(PCT_W), .LO_FAULT(LO_FAULT), .LO_GOOD(LO_GOOD),
      .HI_GOOD(HI_GOOD), .HI_FAULT(HI_FAULT)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .active_i(active),
      .fb_i(fb_pct_i), .in_win_o(in_win)
   );

   pg_retrig_timer #(.LEN(MASK_CYC)) u_mask (
      .clk(clk), .rst_n(rst_n), .clear_i(!en_i),
      .load_i(strobe_ok), .busy_o(mask_busy)
   );

   pg_ready_timer #(.LEN(READY_CYC)) u_rdy (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .ready_o(ser_ready_o)
   );

   assign hold = mask_busy | strobe_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pg_q <= 1'b0;
      else if (!active) pg_q <= 1'b0;
      else if (!hold)   pg_q <= in_win;
   end

   assign pgood_o     = pg_q;
   assign force_ccm_o = mask_busy;

   a_r6_off_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !pgood_o);
   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (active && hold) |=> (pgood_o == $past(pgood_o)));
   a_r7_ccm_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_ok |=> force_ccm_o);
   a_r12_follow_after_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !hold) |=> (pgood_o == $past(in_win)));

endmodule

// File: tb/pg_window_supervisor_tb.sv
module pg_window_supervisor_tb;
   localparam int unsigned MASK  = 12;
   localparam int unsigned READY = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, ss = 1'b0, vid = 1'b0;
   logic [7:0] fb = 8'd0;
   logic pgood, ccm, rdy;

   int checks = 0, fails = 0;
   string pg_tag = "R1", ccm_tag = "R1", rdy_tag = "R1";

   always #2 clk = ~clk;

   pg_window_supervisor #(.MASK_CYC(MASK), .READY_CYC(READY)) u_dut (
      .clk(clk), .rst_n(rst_n), .en_i(en), .ss_done_i(ss), .vid_chg_i(vid),
      .fb_pct_i(fb), .pgood_o(pgood), .force_ccm_o(ccm), .ser_ready_o(rdy)
   );

   // Reference model built from the requirements
   logic m_win, m_pg;
   int   m_mask, m_rdy;

   function automatic logic next_win(logic cur, logic act, logic [7:0] v);
      if (!act) return 1'b0;                  // R6
      if (v < 8'd80 || v > 8'd125) return 1'b0; // R2, R4
      if (v > 8'd85 && v < 8'd120) return 1'b1; // R3, R5
      return cur;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_win <= 1'b0; m_pg <= 1'b0; m_mask <= 0; m_rdy <= 0;
      end else begin
         m_win <= next_win(m_win, en && ss, fb);
         if (!(en && ss)) m_pg <= 1'b0;
         else if (!(m_mask != 0 || (vid && en))) m_pg <= m_win; // R8, R12
         if (!en) m_mask <= 0;                      // R10
         else if (vid) m_mask <= MASK;               // R7, R9
         else if (m_mask > 0) m_mask <= m_mask - 1;
         if (!en) m_rdy <= 0;                        // R11
         else if (m_rdy < READY) m_rdy <= m_rdy + 1;
      end
   end

   task automatic chk(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(pg_tag, "pgood", pgood, m_pg);
      chk(ccm_tag, "force_ccm", ccm, (m_mask != 0));
      chk(rdy_tag, "ser_ready", rdy, (m_rdy == READY));
   endtask

   task automatic cyc(logic e, logic s, logic v, logic [7:0] f);
      @(negedge clk);
      compare_all();
      en = e; ss = s; vid = v; fb = f;
   endtask

   task automatic hold_n(int n, logic e, logic s, logic [7:0] f);
      for (int i = 0; i < n; i++) cyc(e, s, 1'b0, f);
   endtask

   initial begin : watchdog
      #(4 * 150000);
      fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "pgood in reset", pgood, 1'b0);
      chk("R1", "ccm in reset", ccm, 1'b0);
      chk("R1", "ready in reset", rdy, 1'b0);
      rst_n = 1'b1;
      cyc(1'b0, 1'b0, 1'b0, 8'd100);
      // R6: enabled but soft start incomplete
      pg_tag = "R6"; rdy_tag = "R11";
      hold_n(6, 1'b1, 1'b0, 8'd100);
      chk("R6", "pgood before ss_done", pgood, 1'b0);
      pg_tag = "R3";
      hold_n(4, 1'b1, 1'b1, 8'd100);
      chk("R3", "pgood in window", pgood, 1'b1);
      // R2/R3 low side
      pg_tag = "R2";
      hold_n(3, 1'b1, 1'b1, 8'd80);
      chk("R2", "80 keeps good", pgood, 1'b1);
      hold_n(3, 1'b1, 1'b1, 8'd79);
      chk("R2", "79 faults", pgood, 1'b0);
      pg_tag = "R3";
      hold_n(3, 1'b1, 1'b1, 8'd85);
      chk("R3", "85 no recovery", pgood, 1'b0);
      hold_n(3, 1'b1, 1'b1, 8'd86);
      chk("R3", "86 recovers", pgood, 1'b1);
      // R4/R5 high side
      pg_tag = "R4";
      hold_n(3, 1'b1, 1'b1, 8'd125);
      chk("R4", "125 keeps good", pgood, 1'b1);
      hold_n(3, 1'b1, 1'b1, 8'd126);
      chk("R4", "126 faults", pgood, 1'b0);
      pg_tag = "R5";
      hold_n(3, 1'b1, 1'b1, 8'd120);
      chk("R5", "120 no recovery", pgood, 1'b0);
      hold_n(3, 1'b1, 1'b1, 8'd119);
      chk("R5", "119 recovers", pgood, 1'b1);
      // R11: ready after READY edges with enable high
      hold_n(READY, 1'b1, 1'b1, 8'd100);
      chk("R11", "ready asserted", rdy, 1'b1);
      // R7/R8: strobe with feedback leaving window
      pg_tag = "R8"; ccm_tag = "R7";
      cyc(1'b1, 1'b1, 1'b1, 8'd50);
      hold_n(5, 1'b1, 1'b1, 8'd50);
      chk("R8", "pgood frozen high", pgood, 1'b1);
      chk("R7", "ccm forced", ccm, 1'b1);
      // R9: retrigger mid-interval
      ccm_tag = "R9";
      cyc(1'b1, 1'b1, 1'b1, 8'd50);
      hold_n(MASK - 2, 1'b1, 1'b1, 8'd50);
      chk("R9", "still masked after retrigger", ccm, 1'b1);
      // R12: after expiry pgood takes window state
      pg_tag = "R12";
      hold_n(4, 1'b1, 1'b1, 8'd50);
      chk("R12", "pgood follows after mask", pgood, 1'b0);
      chk("R7", "ccm released", ccm, 1'b0);
      // R10: strobe while disabled
      ccm_tag = "R10"; pg_tag = "R6";
      cyc(1'b0, 1'b1, 1'b1, 8'd100);
      hold_n(2, 1'b0, 1'b1, 8'd100);
      chk("R10", "no ccm when disabled", ccm, 1'b0);
      chk("R11", "ready dropped", rdy, 1'b0);
      // Random phase
      pg_tag = "R8"; ccm_tag = "R7";
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] f;
         int k = $urandom_range(0, 9);
         case (k)
            0: f = 8'd79; 1: f = 8'd80; 2: f = 8'd85; 3: f = 8'd86;
            4: f = 8'd119; 5: f = 8'd120; 6: f = 8'd125; 7: f = 8'd126;
            default: f = 8'($urandom_range(60, 140));
         endcase
         cyc(($urandom_range(0, 99) < 97), ($urandom_range(0, 99) < 95),
             ($urandom_range(0, 99) < 3), f);
      end
      cyc(1'b1, 1'b1, 1'b0, 8'd100);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule